// File: doc/BRIEF.md
# Serial Register Port with Burst Readout

This block is a four-wire serial slave that lets a host microcontroller read and write an internal register file. The host frames every exchange with an active-low select. Each exchange is two bytes. The first byte holds a direction flag and a 7-bit register address, and the second byte carries the data. Register storage lives outside the block. The port reaches it through a small parallel bus. The bus has an address, write data, a write strobe, a read strobe, and read data that the register file returns in the same cycle as the read strobe.

All serial inputs are oversampled by the system clock through synchronizer stages. The port works as a serial mode-3 slave. It captures the input line when the serial clock rises and changes the output line when the serial clock falls. A read of one reserved address switches the port into a burst. In a burst it streams a fixed run of motion and image-statistics registers with no further address bytes. The burst stays in force until the select line is released.

Top module: `spi_regport`

## Requirements
- R1: The first byte of a transaction is sent MSB first. Bit 7 is the direction flag (1 = write, 0 = read) and bits 6..0 are the register address. The following byte is the data.
- R2: A write produces exactly one `reg_wr_en` pulse, one system clock wide, carrying the address from the first byte and the data from the second byte. It fires only after the 16th rising serial-clock edge has been captured.
- R3: A read produces exactly one `reg_rd_en` pulse, one clock wide, for the addressed register right after the 8th address bit. The `reg_rdata` value returned in that cycle is the byte shifted out.
- R4: Read data appears on `spi_miso` MSB first. It changes only on falling serial-clock edges, so it is stable at each rising edge. `spi_miso_oe` is high during the data byte and low during the address byte.
- R5: While `spi_cs_n` is high, serial-clock and data activity has no effect. No strobes are issued and `spi_miso_oe` stays low.
- R6: Raising `spi_cs_n` part-way through an address or data byte abandons the transaction with no strobe. The next transaction starts with a fresh address byte.
- R7: Reading address 0x63 starts a burst. The port returns the registers at 0x03, 0x04, 0x05, 0x06, 0x07, 0x08 and 0x09 in that order. It issues one read strobe on entry and one more after each byte it sends.
- R8: Once the burst has reached 0x09, every further byte returns 0x09 again, and its read strobe addresses 0x09.
- R9: During a burst, bytes on `spi_mosi` are ignored. This includes a write pattern or a second 0x63, and no write strobe is issued. Only raising `spi_cs_n` ends the burst, after which a new burst starts again from 0x03.
- R10: With `spi_cs_n` held low, a new address byte may follow a completed write or single read directly.
- R11: After reset, both strobes are low and `spi_miso_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host, idle high |
| spi_mosi | input | 1 | Serial data from the host |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the external tri-state driver on `spi_miso` |
| reg_addr | output | 7 | Register bus address |
| reg_wdata | output | 8 | Register bus write data |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_rd_en | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data from the register file, valid while `reg_rd_en` is high |

## Verification
The bench aims at the burst edges. It clocks ten bytes out of a seven-entry burst, so a port whose index wrapped or ran past the list would return 0x03 data or an out-of-list address. It also sends write and burst patterns on the data line mid-burst, which a port that re-decoded them would answer with a write strobe or a restart. Select is raised part-way through both an address byte and a data byte. A design that kept its bit count across the abort would misframe the following write, and one that completed the write anyway would issue a spurious strobe. Serial-clock toggling while deselected is checked for strobes and for an enabled output. A read placed right after a write under one select checks that the bit counter rolls over cleanly between transactions.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    localparam int ADDR_W    = 7;
    localparam int DATA_W    = ADDR_W + 1;
    localparam int BIT_CNT_W = $clog2(DATA_W);

    // Position of the transaction phases; the encoding is internal only
    typedef enum logic [1:0] {
        PH_ADDR  = 2'd0,
        PH_WDATA = 2'd1,
        PH_RDATA = 2'd2,
        PH_BURST = 2'd3
    } phase_e;

    // One register bus request as seen at the block edge
    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } busreq_t;

    // Burst entries are consecutive registers starting at a base address
    function automatic logic [ADDR_W-1:0] burst_slot_addr(
        input logic [ADDR_W-1:0] base,
        input int unsigned       slot
    );
        return base + ADDR_W'(slot);
    endfunction

    function automatic logic phase_drives_out(input phase_e p);
        return (p == PH_RDATA) || (p == PH_BURST);
    endfunction

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/spi_regport_edge.sv
module spi_regport_edge (
    input  logic clk,
    input  logic rst,
    input  logic sclk_s,
    input  logic cs_n_s,
    output logic cs_act,
    output logic sclk_rise,
    output logic sclk_fall
);

    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b1;
        else     sclk_q <= sclk_s;
    end

    // Edges only count while the port is selected
    assign cs_act    = ~cs_n_s;
    assign sclk_rise = cs_act &  sclk_s & ~sclk_q;
    assign sclk_fall = cs_act & ~sclk_s &  sclk_q;

endmodule

// File: rtl/spi_regport_fsm.sv
module spi_regport_fsm
    import spi_regport_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BURST_CMD  = 7'h63,
    parameter logic [ADDR_W-1:0] BURST_BASE = 7'h03,
    parameter int                BURST_LEN  = 7
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_act,
    input  logic    sclk_rise,
    input  logic    mosi_bit,
    output busreq_t req,
    output logic    drive,
    output logic    burst_mode,
    output logic    byte_start
);

    localparam int                SLOT_W    = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(BURST_LEN - 1);

    phase_e              phase_q, phase_d;
    logic [BIT_CNT_W-1:0] cnt_q, cnt_d;
    logic [DATA_W-1:0]   sh_q, sh_d, sh_in;
    logic [ADDR_W-1:0]   wa_q, wa_d;
    logic [SLOT_W-1:0]   slot_q, slot_d, slot_adv;
    busreq_t             req_d;
    logic                byte_last;

    always_comb begin
        sh_in     = {sh_q[DATA_W-2:0], mosi_bit};
        byte_last = (cnt_q == BIT_CNT_W'(DATA_W - 1));
        slot_adv  = (slot_q == SLOT_LAST) ? slot_q : slot_q + 1'b1;

        phase_d   = phase_q;
        cnt_d     = cnt_q;
        sh_d      = sh_q;
        wa_d      = wa_q;
        slot_d    = slot_q;
        req_d     = req;
        req_d.wr  = 1'b0;
        req_d.rd  = 1'b0;

        if (!cs_act) begin
            phase_d = PH_ADDR;
            cnt_d   = '0;
            slot_d  = '0;
        end else if (sclk_rise) begin
            cnt_d = cnt_q + 1'b1;
            case (phase_q)
                PH_ADDR: begin
                    sh_d = sh_in;
                    if (byte_last) begin
                        if (sh_in[DATA_W-1]) begin
                            phase_d = PH_WDATA;
                            wa_d    = sh_in[ADDR_W-1:0];
                        end else if (sh_in[ADDR_W-1:0] == BURST_CMD) begin
                            phase_d    = PH_BURST;
                            slot_d     = '0;
                            req_d.rd   = 1'b1;
                            req_d.addr = burst_slot_addr(BURST_BASE, 0);
                        end else begin
                            phase_d    = PH_RDATA;
                            req_d.rd   = 1'b1;
                            req_d.addr = sh_in[ADDR_W-1:0];
                        end
                    end
                end
                PH_WDATA: begin
                    sh_d = sh_in;
                    if (byte_last) begin
                        phase_d     = PH_ADDR;
                        req_d.wr    = 1'b1;
                        req_d.addr  = wa_q;
                        req_d.wdata = sh_in;
                    end
                end
                PH_RDATA: begin
                    if (byte_last) phase_d = PH_ADDR;
                end
                PH_BURST: begin
                    // Input bits are discarded; the slot saturates at the last entry
                    if (byte_last) begin
                        slot_d     = slot_adv;
                        req_d.rd   = 1'b1;
                        req_d.addr = burst_slot_addr(BURST_BASE, int'(slot_adv));
                    end
                end
                default: phase_d = PH_ADDR;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_ADDR;
            cnt_q   <= '0;
            sh_q    <= '0;
            wa_q    <= '0;
            slot_q  <= '0;
            req     <= '0;
            drive   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
            wa_q    <= wa_d;
            slot_q  <= slot_d;
            req     <= req_d;
            drive   <= cs_act && phase_drives_out(phase_d);
        end
    end

    assign burst_mode = (phase_q == PH_BURST);
    assign byte_start = (cnt_q == '0);

endmodule

// File: rtl/spi_regport_tx.sv
module spi_regport_tx
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              sclk_fall,
    input  logic              byte_start,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              miso
);

    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] out_q;

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            hold_q <= '0;
            out_q  <= '0;
        end else begin
            if (load) hold_q <= load_data;
            if (sclk_fall) begin
                out_q <= byte_start ? hold_q : {out_q[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign miso = out_q[DATA_W-1];

endmodule

// File: rtl/spi_regport.sv
module spi_regport
    import spi_regport_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] BURST_CMD   = 7'h63,
    parameter logic [ADDR_W-1:0] BURST_BASE  = 7'h03,
    parameter int                BURST_LEN   = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    input  logic              spi_cs_n,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_wr_en,
    output logic              reg_rd_en,
    input  logic [DATA_W-1:0] reg_rdata
);

    logic [2:0] pins_raw, pins_s;
    logic       cs_act, sclk_rise, sclk_fall;
    logic       drive, burst_mode, byte_start;
    busreq_t    req;

    assign pins_raw = {spi_cs_n, spi_sclk, spi_mosi};

    spi_regport_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b110)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (pins_raw),
        .q  (pins_s)
    );

    spi_regport_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .sclk_s   (pins_s[1]),
        .cs_n_s   (pins_s[2]),
        .cs_act   (cs_act),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall)
    );

    spi_regport_fsm #(
        .BURST_CMD (BURST_CMD),
        .BURST_BASE(BURST_BASE),
        .BURST_LEN (BURST_LEN)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .mosi_bit  (pins_s[0]),
        .req       (req),
        .drive     (drive),
        .burst_mode(burst_mode),
        .byte_start(byte_start)
    );

    spi_regport_tx u_tx (
        .clk       (clk),
        .rst       (rst),
        .cs_act    (cs_act),
        .sclk_fall (sclk_fall),
        .byte_start(byte_start),
        .load      (req.rd),
        .load_data (reg_rdata),
        .miso      (spi_miso)
    );

    assign spi_miso_oe = drive;
    assign reg_addr    = req.addr;
    assign reg_wdata   = req.wdata;
    assign reg_wr_en   = req.wr;
    assign reg_rd_en   = req.rd;

endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk
    import spi_regport_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BURST_BASE = 7'h03,
    parameter int                BURST_LEN  = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_act,
    input logic              burst_mode,
    input logic              spi_miso_oe,
    input logic              reg_wr_en,
    input logic              reg_rd_en,
    input logic [ADDR_W-1:0] reg_addr
);

    localparam logic [ADDR_W-1:0] BURST_TOP = BURST_BASE + ADDR_W'(BURST_LEN - 1);

    // R2
    wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> !reg_wr_en);

    // R3
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rd_en |=> !reg_rd_en);

    // R1
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr_en && reg_rd_en));

    // R5
    desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> !spi_miso_oe);

    // R6
    abort_nostrobe_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> !(reg_wr_en || reg_rd_en));

    // R8
    burst_range_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_en && burst_mode) |-> (reg_addr >= BURST_BASE && reg_addr <= BURST_TOP));

    // R9
    burst_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        burst_mode |-> !reg_wr_en);

endmodule

bind spi_regport spi_regport_chk #(
    .BURST_BASE(BURST_BASE),
    .BURST_LEN (BURST_LEN)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_act     (cs_act),
    .burst_mode (burst_mode),
    .spi_miso_oe(spi_miso_oe),
    .reg_wr_en  (reg_wr_en),
    .reg_rd_en  (reg_rd_en),
    .reg_addr   (reg_addr)
);

// File: tb/tb_spi_regport.sv
`timescale 1ns/1ps
module tb_spi_regport;

    localparam int H = 8;  // system clocks per serial half period

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b1;
    logic       mosi = 1'b0;
    logic       cs_n = 1'b1;
    logic       spi_miso, spi_miso_oe;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       reg_wr_en, reg_rd_en;
    logic       done = 1'b0;

    always #2.5 clk = ~clk;

    spi_regport dut (
        .clk        (clk),
        .rst        (rst),
        .spi_sclk   (sclk),
        .spi_mosi   (mosi),
        .spi_cs_n   (cs_n),
        .spi_miso   (spi_miso),
        .spi_miso_oe(spi_miso_oe),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_wr_en  (reg_wr_en),
        .reg_rd_en  (reg_rd_en),
        .reg_rdata  (reg_rdata)
    );

    // Register file model: every address returns a distinct byte
    function automatic logic [7:0] model(input logic [6:0] a);
        return {1'b0, a} ^ 8'h5C;
    endfunction
    assign reg_rdata = model(reg_addr);

    typedef struct packed {
        logic       wr;
        logic [6:0] a;
        logic [7:0] d;
    } ev_t;

    ev_t   exp_q[$];
    string tag_q[$];
    int    n_chk = 0;
    int    n_bad = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic wr, input logic [6:0] a, input logic [7:0] d, input string tag);
        ev_t e;
        e.wr = wr; e.a = a; e.d = wr ? d : 8'h00;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: pops one expected bus event per strobe
    always @(negedge clk) begin
        if (!rst && (reg_wr_en || reg_rd_en)) begin
            ev_t   got, want;
            string t;
            got.wr = reg_wr_en; got.a = reg_addr; got.d = reg_wr_en ? reg_wdata : 8'h00;
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R2/R3/R5/R6/R9 unexpected strobe: actual %0h expected none", got);
            end else begin
                want = exp_q.pop_front();
                t    = tag_q.pop_front();
                check(t, 32'(got), 32'(want));
            end
        end
    end

    task automatic hwait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int n,
                            output logic [7:0] rx, output logic oe_all);
        rx = '0; oe_all = 1'b1;
        for (int i = 7; i >= 8 - n; i--) begin
            sclk = 1'b0; mosi = tx[i];
            hwait(H);
            rx[i]  = spi_miso;
            oe_all = oe_all & spi_miso_oe;
            sclk = 1'b1;
            hwait(H);
        end
    endtask

    task automatic cs_lo();
        cs_n = 1'b0; hwait(4);
    endtask

    task automatic cs_hi();
        hwait(H); cs_n = 1'b1; hwait(8);
    endtask

    task automatic wr_core(input logic [6:0] a, input logic [7:0] d, input string tag);
        logic [7:0] rx; logic oe;
        push(1'b1, a, d, tag);
        spi_bits({1'b1, a}, 8, rx, oe);
        spi_bits(d, 8, rx, oe);
    endtask

    task automatic rd_core(input logic [6:0] a, input string tag);
        logic [7:0] rx, dummy; logic oe_a, oe_d;
        push(1'b0, a, 8'h00, {tag, " read strobe"});
        spi_bits({1'b0, a}, 8, dummy, oe_a);
        hwait(4);
        spi_bits(8'h00, 8, rx, oe_d);
        check({tag, " R4 miso byte"}, rx, model(a));
        check("R4 oe high through data byte", oe_d, 1);
        check("R4 oe low during address byte", oe_a, 0);
    endtask

    task automatic do_read(input logic [6:0] a, input string tag);
        cs_lo(); rd_core(a, tag); cs_hi();
        check("R5 oe low after deselect", spi_miso_oe, 0);
    endtask

    initial begin
        logic [7:0] rx;
        logic       oe;

        hwait(10);
        rst = 1'b0;
        hwait(4);
        // R11 reset state
        check("R11 write strobe after reset", reg_wr_en, 0);
        check("R11 read strobe after reset", reg_rd_en, 0);
        check("R11 oe after reset", spi_miso_oe, 0);

        // R1 R2 plain write, then reads with varied patterns
        cs_lo(); wr_core(7'h05, 8'h3C, "R2 write 05"); cs_hi();
        do_read(7'h05, "R3 read 05");
        do_read(7'h2A, "R1 read 2A");
        do_read(7'h7F, "R1 read 7F");
        do_read(7'h00, "R3 read 00");

        // R5 activity while deselected: no strobe, no drive
        for (int i = 0; i < 16; i++) begin
            sclk = 1'b0; mosi = i[0]; hwait(H);
            check("R5 oe while deselected", spi_miso_oe, 0);
            sclk = 1'b1; hwait(H);
        end
        do_read(7'h11, "R5 read after ignored clocks");

        // R6 abort inside the data byte and inside the address byte
        cs_lo(); spi_bits(8'h8A, 8, rx, oe); spi_bits(8'hF0, 4, rx, oe); cs_hi();
        cs_lo(); spi_bits(8'h8B, 3, rx, oe); cs_hi();
        cs_lo(); wr_core(7'h06, 8'hC3, "R6 write after abort"); cs_hi();
        do_read(7'h06, "R6 read after abort");

        // R10 back-to-back transactions under one select
        cs_lo();
        wr_core(7'h01, 8'h11, "R10 first write");
        rd_core(7'h02, "R10 following read");
        wr_core(7'h0D, 8'hA5, "R10 trailing write");
        cs_hi();

        // R7 R8 long burst: ten bytes from a seven-entry list
        for (int k = 0; k <= 10; k++) begin
            push(1'b0, 7'(3 + ((k > 6) ? 6 : k)), 8'h00, "R7/R8 burst strobe");
        end
        cs_lo();
        spi_bits(8'h63, 8, rx, oe);
        hwait(4);
        for (int k = 0; k < 10; k++) begin
            spi_bits(8'h00, 8, rx, oe);
            check((k > 6) ? "R8 burst sticks at last entry" : "R7 burst sequence",
                  rx, model(7'(3 + ((k > 6) ? 6 : k))));
        end
        cs_hi();

        // R9 command-like input inside a burst is ignored
        for (int k = 0; k <= 2; k++) push(1'b0, 7'(3 + k), 8'h00, "R9 burst strobe");
        cs_lo();
        spi_bits(8'h63, 8, rx, oe);
        hwait(4);
        spi_bits(8'hE3, 8, rx, oe);
        check("R9 byte 0 with write pattern on input", rx, model(7'h03));
        spi_bits(8'h63, 8, rx, oe);
        check("R9 byte 1 with burst pattern on input", rx, model(7'h04));
        cs_hi();
        check("R9 oe low after burst exit", spi_miso_oe, 0);

        // R9 a fresh burst restarts from the first entry
        for (int k = 0; k <= 1; k++) push(1'b0, 7'(3 + k), 8'h00, "R9 restart strobe");
        cs_lo();
        spi_bits(8'h63, 8, rx, oe);
        hwait(4);
        spi_bits(8'h00, 8, rx, oe);
        check("R9 restarted burst first byte", rx, model(7'h03));
        cs_hi();

        hwait(20);
        check("R7 all expected strobes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule